// File: doc/BRIEF.md
# Peripheral Input Routing Matrix

This block feeds every peripheral input signal of a chip from a selectable source. Each peripheral input (there are `NUM_SIGS` of them, up to 256) has its own configuration entry. The entry picks one of the `NUM_PINS` synchronized pin inputs, a constant 0 or a constant 1. It can also take a dedicated, directly wired pin in place of the matrix. The final value can be inverted.

Configuration is held in one register per peripheral input, written through a simple single-cycle write port and read back combinationally through a read port. The routed outputs are purely combinational from the pin inputs and the stored configuration, so a pin change reaches the peripheral in the same cycle. Pin synchronization happens upstream and is not part of this block.

There is no sequencing in this block. Its only state is the register file: one entry per signal, with a reset value and a write transition that takes effect at the next clock edge.

Top module: `rim_input_matrix`

## Requirements
- R1: After reset, every configuration entry reads back as 0x00000030 and every `sig_out` bit is 0, whatever the pins do.
- R2: With bypass clear and select field (bits 5:0) equal to n, where n < `NUM_PINS`, `sig_out[i]` follows `pin_in[n]`, XORed with the invert bit.
- R3: A select value of 0x30 gives a constant 0 before inversion.
- R4: A select value of 0x38 gives a constant 1 before inversion.
- R5: Any other select value (at least `NUM_PINS` and neither 0x30 nor 0x38) gives a constant 0 before inversion.
- R6: Invert (bit 6) complements the final value. This includes the constants, so an inverted 0x30 yields 1 and an inverted 0x38 yields 0.
- R7: Bypass (bit 7) makes `sig_out[i]` follow `direct_in[i]` instead of the matrix, with the invert bit still applied.
- R8: A write with `wr_en` high at a rising edge updates only entry `wr_addr`, and the new value is visible on readback after that edge. A clock edge with `wr_en` low changes no entry.
- R9: Bits 31:8 of a write are discarded and always read back as zero.
- R10: `sig_out` responds to `pin_in` and `direct_in` combinationally, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration registers |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for a configuration entry |
| wr_addr | input | ADDR_W | Index of the entry to write |
| wr_data | input | 32 | Write value: select in 5:0, invert in 6, bypass in 7 |
| rd_addr | input | ADDR_W | Index of the entry to read back |
| rd_data | output | 32 | Readback of entry `rd_addr`, upper 24 bits zero |
| pin_in | input | NUM_PINS | Synchronized pin levels |
| direct_in | input | NUM_SIGS | Dedicated direct pin per peripheral input |
| sig_out | output | NUM_SIGS | Routed peripheral input values |

## Verification
On every cycle, the assertions take the entry selected by `rd_addr` and check its lane against the routing rule for that entry's select, invert and bypass bits. They also check that reserved readback bits are zero, that a write is visible on the next cycle, and the reset value. Several behaviours are left to the bench's scenarios: that writes leave the other entries untouched, that an idle write strobe stores nothing, that a pin edge reaches an output without a clock, and that every pin index can be routed.

// File: rtl/rim_pkg.sv
package rim_pkg;
    localparam int SEL_W      = 6;
    localparam int CFG_W      = 8;
    localparam int BUS_W      = 32;
    localparam logic [SEL_W-1:0] SEL_FORCE0 = 6'h30;
    localparam logic [SEL_W-1:0] SEL_FORCE1 = 6'h38;

    typedef struct packed {
        logic             byp;
        logic             inv;
        logic [SEL_W-1:0] sel;
    } rim_cfg_t;

    localparam rim_cfg_t CFG_RESET = '{byp: 1'b0, inv: 1'b0, sel: SEL_FORCE0};
endpackage

// File: rtl/rim_cfg_regs.sv
module rim_cfg_regs
    import rim_pkg::*;
#(
    parameter int NUM_SIGS = 16,
    parameter int ADDR_W   = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [ADDR_W-1:0]              wr_addr,
    input  rim_cfg_t                       wr_cfg,
    output rim_cfg_t [NUM_SIGS-1:0]        cfg_vec
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_SIGS; i++) begin
                cfg_vec[i] <= CFG_RESET;
            end
        end else if (wr_en) begin
            for (int i = 0; i < NUM_SIGS; i++) begin
                if (wr_addr == ADDR_W'(i)) begin
                    cfg_vec[i] <= wr_cfg;
                end
            end
        end
    end
endmodule

// File: rtl/rim_lane.sv
module rim_lane
    import rim_pkg::*;
#(
    parameter int NUM_PINS = 40
) (
    input  rim_cfg_t              cfg,
    input  logic [NUM_PINS-1:0]   pin_in,
    input  logic                  direct_bit,
    output logic                  out_bit
);
    localparam int PAD_W = 1 << SEL_W;

    logic [PAD_W-1:0] pins_pad;
    logic             matrix_val;
    logic             src_val;

    always_comb begin
        pins_pad = '0;
        pins_pad[NUM_PINS-1:0] = pin_in;
    end

    always_comb begin
        if (int'(cfg.sel) < NUM_PINS) begin
            matrix_val = pins_pad[cfg.sel];
        end else if (cfg.sel == SEL_FORCE1) begin
            matrix_val = 1'b1;
        end else begin
            matrix_val = 1'b0;
        end
        src_val = cfg.byp ? direct_bit : matrix_val;
        out_bit = src_val ^ cfg.inv;
    end
endmodule

// File: rtl/rim_input_matrix.sv
module rim_input_matrix
    import rim_pkg::*;
#(
    parameter int NUM_PINS = 40,
    parameter int NUM_SIGS = 16,
    localparam int ADDR_W  = (NUM_SIGS > 1) ? $clog2(NUM_SIGS) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  logic [BUS_W-1:0]      wr_data,
    input  logic [ADDR_W-1:0]     rd_addr,
    output logic [BUS_W-1:0]      rd_data,
    input  logic [NUM_PINS-1:0]   pin_in,
    input  logic [NUM_SIGS-1:0]   direct_in,
    output logic [NUM_SIGS-1:0]   sig_out
);
    rim_cfg_t [NUM_SIGS-1:0] cfg_vec;
    rim_cfg_t                wr_cfg;

    assign wr_cfg = rim_cfg_t'(wr_data[CFG_W-1:0]);

    rim_cfg_regs #(
        .NUM_SIGS (NUM_SIGS),
        .ADDR_W   (ADDR_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_cfg  (wr_cfg),
        .cfg_vec (cfg_vec)
    );

    for (genvar g = 0; g < NUM_SIGS; g++) begin : g_lane
        rim_lane #(
            .NUM_PINS (NUM_PINS)
        ) u_lane (
            .cfg        (cfg_vec[g]),
            .pin_in     (pin_in),
            .direct_bit (direct_in[g]),
            .out_bit    (sig_out[g])
        );
    end

    always_comb begin
        rd_data = '0;
        if (int'(rd_addr) < NUM_SIGS) begin
            rd_data[CFG_W-1:0] = cfg_vec[rd_addr];
        end
    end
endmodule

// File: rtl/rim_input_matrix_chk.sv
module rim_input_matrix_chk
    import rim_pkg::*;
#(
    parameter int NUM_PINS = 40,
    parameter int NUM_SIGS = 16,
    parameter int ADDR_W   = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  wr_en,
    input logic [ADDR_W-1:0]     wr_addr,
    input logic [BUS_W-1:0]      wr_data,
    input logic [ADDR_W-1:0]     rd_addr,
    input logic [BUS_W-1:0]      rd_data,
    input logic [NUM_PINS-1:0]   pin_in,
    input logic [NUM_SIGS-1:0]   direct_in,
    input logic [NUM_SIGS-1:0]   sig_out
);
    localparam int PAD_W = 1 << SEL_W;

    rim_cfg_t         rb;
    logic             lane_ok;
    logic             lane_val;
    logic             dir_val;
    logic             pin_val;
    logic             is_pin;
    logic             is_other;
    logic [PAD_W-1:0] pad;

    always_comb begin
        rb       = rim_cfg_t'(rd_data[CFG_W-1:0]);
        lane_ok  = int'(rd_addr) < NUM_SIGS;
        lane_val = lane_ok ? sig_out[rd_addr] : 1'b0;
        dir_val  = lane_ok ? direct_in[rd_addr] : 1'b0;
        pad      = '0;
        pad[NUM_PINS-1:0] = pin_in;
        pin_val  = pad[rb.sel];
        is_pin   = int'(rb.sel) < NUM_PINS;
        is_other = !is_pin && rb.sel != SEL_FORCE0 && rb.sel != SEL_FORCE1;
    end

    a_r1_reset_value: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> rd_data == {{(BUS_W-CFG_W){1'b0}}, CFG_RESET});

    a_r2_pin_route: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_ok && !rb.byp && is_pin) |-> lane_val == (pin_val ^ rb.inv));

    a_r3_force_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_ok && !rb.byp && rb.sel == SEL_FORCE0) |-> lane_val == rb.inv);

    a_r4_force_one: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_ok && !rb.byp && rb.sel == SEL_FORCE1) |-> lane_val == !rb.inv);

    a_r5_other_code: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_ok && !rb.byp && is_other) |-> lane_val == rb.inv);

    a_r7_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_ok && rb.byp) |-> lane_val == (dir_val ^ rb.inv));

    a_r8_write_readback: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && int'(wr_addr) < NUM_SIGS) |=>
            (rd_addr != $past(wr_addr)) ||
            (rd_data == ($past(wr_data) & {{(BUS_W-CFG_W){1'b0}}, {CFG_W{1'b1}}})));

    a_r9_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[BUS_W-1:CFG_W] == '0);
endmodule

bind rim_input_matrix rim_input_matrix_chk #(
    .NUM_PINS (NUM_PINS),
    .NUM_SIGS (NUM_SIGS),
    .ADDR_W   (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .pin_in    (pin_in),
    .direct_in (direct_in),
    .sig_out   (sig_out)
);

// File: tb/test_rim_input_matrix.sv
`timescale 1ns/1ps
module test_rim_input_matrix;
    localparam int NP = 40;
    localparam int NS = 16;
    localparam int AW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [31:0]   wr_data = '0;
    logic [AW-1:0] rd_addr = '0;
    logic [31:0]   rd_data;
    logic [NP-1:0] pin_in = '0;
    logic [NS-1:0] direct_in = '0;
    logic [NS-1:0] sig_out;

    logic [7:0] shadow [NS];
    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    rim_input_matrix #(.NUM_PINS(NP), .NUM_SIGS(NS)) i_rim_input_matrix (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .pin_in(pin_in), .direct_in(direct_in), .sig_out(sig_out)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic model(int i);
        logic [7:0] c;
        logic v;
        c = shadow[i];
        if (c[7])                 v = direct_in[i];
        else if (c[5:0] < 6'(NP)) v = pin_in[c[5:0]];
        else if (c[5:0] == 6'h38) v = 1'b1;
        else                      v = 1'b0;
        return v ^ c[6];
    endfunction

    function automatic logic [NS-1:0] model_all();
        logic [NS-1:0] r;
        for (int i = 0; i < NS; i++) r[i] = model(i);
        return r;
    endfunction

    task automatic wr(int a, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        shadow[a] = d[7:0];
    endtask

    task automatic chk_out(string req);
        #0.5;
        chk(req, 32'(sig_out), 32'(model_all()));
    endtask

    task automatic chk_readback_all(string req);
        for (int i = 0; i < NS; i++) begin
            rd_addr = AW'(i);
            #0.2;
            chk(req, rd_data, {24'b0, shadow[i]});
        end
    endtask

    task automatic t_reset;
        for (int i = 0; i < NS; i++) shadow[i] = 8'h30;
        chk_readback_all("R1 readback");
        pin_in = '1; direct_in = '1;
        #0.5;
        chk("R1 outputs", 32'(sig_out), 32'h0);
        pin_in = '0; direct_in = '0;
    endtask

    task automatic t_route;
        for (int p = 0; p < NP; p++) begin
            wr(p % NS, 32'(p));
            pin_in = '0;
            chk_out("R2 pin low");
            pin_in = NP'(1) << p;
            chk_out("R2 pin high");
        end
        pin_in = '0;
    endtask

    task automatic t_comb;
        wr(3, 32'd17);
        pin_in = '0;
        #0.5;
        chk("R10 low", 32'(sig_out[3]), 32'd0);
        pin_in[17] = 1'b1;
        #0.3;
        chk("R10 high no edge", 32'(sig_out[3]), 32'd1);
        pin_in = '0;
    endtask

    task automatic t_const;
        wr(0, 32'h30);
        wr(1, 32'h38);
        pin_in = '1;
        #0.5;
        chk("R3 force0", 32'(sig_out[0]), 32'd0);
        chk("R4 force1", 32'(sig_out[1]), 32'd1);
        pin_in = '0;
        #0.5;
        chk("R4 force1 pins low", 32'(sig_out[1]), 32'd1);
    endtask

    task automatic t_other;
        pin_in = '1;
        wr(2, 32'h28);
        #0.5; chk("R5 code 0x28", 32'(sig_out[2]), 32'd0);
        wr(2, 32'h3F);
        #0.5; chk("R5 code 0x3F", 32'(sig_out[2]), 32'd0);
        wr(2, 32'h31);
        #0.5; chk("R5 code 0x31", 32'(sig_out[2]), 32'd0);
        pin_in = '0;
    endtask

    task automatic t_invert;
        wr(4, 32'h70);
        wr(5, 32'h78);
        wr(6, 32'h40 | 32'd9);
        #0.5;
        chk("R6 inv force0", 32'(sig_out[4]), 32'd1);
        chk("R6 inv force1", 32'(sig_out[5]), 32'd0);
        chk("R6 inv pin low", 32'(sig_out[6]), 32'd1);
        pin_in[9] = 1'b1;
        #0.5;
        chk("R6 inv pin high", 32'(sig_out[6]), 32'd0);
        pin_in = '0;
    endtask

    task automatic t_bypass;
        wr(7, 32'h80 | 32'h38);
        wr(8, 32'hC0 | 32'd2);
        direct_in = '0; pin_in = '1;
        chk_out("R7 bypass direct low");
        direct_in[7] = 1'b1; direct_in[8] = 1'b1;
        chk_out("R7 bypass direct high");
        pin_in = '0; direct_in = '0;
    endtask

    task automatic t_write;
        wr(10, 32'h15);
        chk_readback_all("R8 only target changed");
        @(negedge clk);
        wr_addr = AW'(10); wr_data = 32'h3A;
        @(negedge clk);
        wr_data = '0;
        rd_addr = AW'(10);
        #0.2;
        chk("R8 no write when idle", rd_data, 32'h15);
        wr(NS - 1, 32'h22);
        chk_readback_all("R8 last entry");
        chk_out("R8 outputs");
    endtask

    task automatic t_reserved;
        wr(11, 32'hFFFF_FF38);
        rd_addr = AW'(11);
        #0.2;
        chk("R9 reserved dropped", rd_data, 32'h38);
        #0.3;
        chk("R9 outputs", 32'(sig_out[11]), 32'd1);
    endtask

    initial begin
        #400000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_route;
        t_comb;
        t_const;
        t_other;
        t_invert;
        t_bypass;
        t_write;
        t_reserved;
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule